// File: doc/BRIEF.md
# Dual-Mode Converter Serial Output Model

This block is a synthesizable model of the digital output side of a 16-bit sampling converter. A host-side receiver uses it as its stimulus source. It runs on a system clock. The convert strobe, the host shift clock and the mode strap are all treated as slow synchronous levels, and the block finds their edges itself.

A rising edge on the convert strobe captures the externally supplied sample word and starts a conversion. The conversion lasts a fixed number of system cycles. Strobes that arrive during the conversion are ignored. When the conversion ends, the word becomes the current result. The host then reads it bit by bit, and each falling edge of its shift clock launches the next bit.

The mode strap selects one of two framings:
- Echoed-clock mode sends the bare 16-bit word and copies the shift clock back out.
- Self-clocked mode sends a short synchronisation header ahead of the word and keeps the echoed clock low.

A later conversion closes the readout window of the previous word at a fixed offset. Any bits not yet read at that point are lost, and a flag records the loss.

The conversion controller has two states. CV_IDLE moves to CV_RUN on an accepted strobe. CV_RUN returns to CV_IDLE on its last latency cycle, and that transition loads the result.

The shifter also has two states. SH_QUIET moves to SH_ACTIVE on a result load. SH_ACTIVE returns to SH_QUIET in two cases: on the falling shift edge that follows the last bit, or when the readout window closes.

Top module: `adc_ser_model`

## Requirements
- R1: A rising edge of `cnv_i` while no conversion runs captures `sample_i` and holds `busy_o` high for exactly LAT_CYC system cycles, starting in the cycle after the edge.
- R2: A rising edge of `cnv_i` while `busy_o` is high has no effect. This includes an edge in the final busy cycle. The conversion does not restart, its length does not change, and the captured word is unchanged.
- R3: In the first cycle after `busy_o` falls, `sdata_o` shows the first frame bit. In echoed-clock mode this is the word MSB. In self-clocked mode it is 1, or 0 when EARLY_REV=1.
- R4: When `echo_strap_i`=1, the frame is the 16-bit two's complement word, sent MSB first. Falling edge k of `sclk_i` (k=1..15) launches bit 15-k. The 16th falling edge returns `sdata_o` to 0.
- R5: When `echo_strap_i`=0, the idle-low line is followed by the header 1,0 and then the word MSB first. That is 18 pulses, and the 18th falling edge returns the line to 0. With EARLY_REV=1 the header is 0,1,0, giving 19 pulses.
- R6: In echoed-clock mode `dco_o` equals `sclk_i` outside the blanking interval. In self-clocked mode `dco_o` is 0.
- R7: `sdata_o` and `dco_o` are both 0 during the blanking interval. The interval runs from CUT_CYC cycles after an accepted strobe until the result loads.
- R8: If a word is still being read when the window closes, its remaining bits are dropped and `lost_o` goes to 1 in that cycle. `lost_o` stays 1 until the next result load clears it. A word that was read in full leaves `lost_o` at 0.
- R9: After reset, `busy_o`, `sdata_o` and `lost_o` are 0.
- R10: Shift clock edges while no word is active leave `sdata_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv_i | input | 1 | Convert strobe; a rising edge starts a conversion |
| sample_i | input | DATA_W | Word captured at the accepted strobe |
| sclk_i | input | 1 | Host shift clock; falling edges launch bits |
| echo_strap_i | input | 1 | 1 = echoed-clock mode, 0 = self-clocked mode |
| sdata_o | output | 1 | Serial data line |
| dco_o | output | 1 | Echoed shift clock |
| busy_o | output | 1 | Conversion in progress |
| lost_o | output | 1 | Readout cut short by the window closing |

## Verification
The hardest situation to reach is a readout that is interrupted part-way by the next conversion. Reaching it means placing a new strobe while a word is still being shifted, and then observing the exact cycle in which the line and the echoed clock go dark.

The bench reads a varying number of bits from a word, from none up to all of them, and then issues the next strobe with the shift clock held high. This makes a blanked echoed clock visible at the port. The bench then checks the loss flag one cycle before and one cycle after the window edge.

A second hard case is a strobe that lands exactly on the last busy cycle. The bench counts busy cycles and raises the strobe on that cycle, so it falls on the result-load edge.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

    typedef enum logic {
        CV_IDLE,
        CV_RUN
    } conv_state_e;

    typedef enum logic {
        SH_QUIET,
        SH_ACTIVE
    } shift_state_e;

endpackage

// File: rtl/adc_ser_edge.sv
module adc_ser_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_i;
    end

    always_comb begin
        rise_o = sig_i & ~prev_q;
        fall_o = ~sig_i & prev_q;
    end
endmodule

// File: rtl/adc_ser_conv.sv
module adc_ser_conv
    import adc_ser_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int LAT_CYC = 32,
    parameter int CUT_CYC = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_rise_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              busy_o,
    output logic              load_o,
    output logic              cut_o,
    output logic              blank_o,
    output logic [DATA_W-1:0] word_o
);
    localparam int CNT_W = $clog2(LAT_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LAT_CYC - 1);
    localparam logic [CNT_W-1:0] CUT_CNT  = CNT_W'(CUT_CYC - 1);
    localparam logic [CNT_W-1:0] BLK_CNT  = CNT_W'(CUT_CYC);

    conv_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [DATA_W-1:0] word_q, word_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CV_IDLE;
            cnt_q   <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            word_q  <= word_d;
        end
    end

    // Transitions: CV_IDLE -(strobe)-> CV_RUN -(last cycle)-> CV_IDLE
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        word_d  = word_q;
        unique case (state_q)
            CV_IDLE: begin
                if (start_rise_i) begin
                    state_d = CV_RUN;
                    cnt_d   = '0;
                    word_d  = sample_i;
                end
            end
            CV_RUN: begin
                if (cnt_q == LAST_CNT) begin
                    state_d = CV_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = CV_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy_o  = (state_q == CV_RUN);
        load_o  = (state_q == CV_RUN) && (cnt_q == LAST_CNT);
        cut_o   = (state_q == CV_RUN) && (cnt_q == CUT_CNT);
        blank_o = (state_q == CV_RUN) && (cnt_q >= BLK_CNT);
        word_o  = word_q;
    end

    assert_start_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CV_IDLE && start_rise_i) |=> (busy_o && cnt_q == '0 && word_q == $past(sample_i)));

    assert_strobe_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CV_RUN && start_rise_i) |=> $stable(word_q));

    assert_busy_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cnt_q <= LAST_CNT));
endmodule

// File: rtl/adc_ser_shift.sv
module adc_ser_shift
    import adc_ser_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int EARLY_REV = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              cut_i,
    input  logic              fall_i,
    input  logic              echo_mode_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              sdata_o,
    output logic              lost_o
);
    localparam int HDR_LEN = (EARLY_REV != 0) ? 3 : 2;
    localparam int FMAX    = DATA_W + HDR_LEN;
    localparam int BC_W    = $clog2(FMAX + 1);
    localparam logic [BC_W-1:0] ECHO_LAST = BC_W'(DATA_W - 1);
    localparam logic [BC_W-1:0] SELF_LAST = BC_W'(FMAX - 1);

    shift_state_e      st_q, st_d;
    logic [FMAX-1:0]   sh_q, sh_d;
    logic [BC_W-1:0]   bc_q, bc_d;
    logic [BC_W-1:0]   last_q, last_d;
    logic              lost_q, lost_d;
    logic [FMAX-1:0]   self_frame;
    logic [FMAX-1:0]   echo_frame;

    generate
        if (EARLY_REV != 0) begin : g_hdr_early
            assign self_frame = {3'b010, word_i};
        end else begin : g_hdr_std
            assign self_frame = {2'b10, word_i};
        end
    endgenerate

    assign echo_frame = {word_i, {HDR_LEN{1'b0}}};

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SH_QUIET;
            sh_q   <= '0;
            bc_q   <= '0;
            last_q <= '0;
            lost_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            sh_q   <= sh_d;
            bc_q   <= bc_d;
            last_q <= last_d;
            lost_q <= lost_d;
        end
    end

    // Transitions: SH_QUIET -(load)-> SH_ACTIVE -(final fall | cut)-> SH_QUIET
    always_comb begin
        st_d   = st_q;
        sh_d   = sh_q;
        bc_d   = bc_q;
        last_d = last_q;
        lost_d = lost_q;
        if (load_i) begin
            st_d   = SH_ACTIVE;
            sh_d   = echo_mode_i ? echo_frame : self_frame;
            bc_d   = '0;
            last_d = echo_mode_i ? ECHO_LAST : SELF_LAST;
            lost_d = 1'b0;
        end else if (cut_i) begin
            if (st_q == SH_ACTIVE) begin
                st_d   = SH_QUIET;
                lost_d = 1'b1;
            end
        end else begin
            unique case (st_q)
                SH_QUIET: begin
                    st_d = SH_QUIET;
                end
                SH_ACTIVE: begin
                    if (fall_i) begin
                        if (bc_q == last_q) begin
                            st_d = SH_QUIET;
                        end else begin
                            sh_d = {sh_q[FMAX-2:0], 1'b0};
                            bc_d = bc_q + 1'b1;
                        end
                    end
                end
                default: st_d = SH_QUIET;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sdata_o = (st_q == SH_ACTIVE) ? sh_q[FMAX-1] : 1'b0;
        lost_o  = lost_q;
    end

    assert_bit_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SH_ACTIVE) |-> (bc_q <= last_q));

    assert_lost_only_on_cut_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost_o) |-> $past(cut_i));

    assert_cut_while_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cut_i && st_q == SH_ACTIVE) |=> (lost_o && !sdata_o));

    assert_idle_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SH_QUIET && !load_i) |=> !sdata_o);
endmodule

// File: rtl/adc_ser_model.sv
module adc_ser_model #(
    parameter int DATA_W    = 16,
    parameter int LAT_CYC   = 32,
    parameter int CUT_CYC   = 10,
    parameter int EARLY_REV = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              sclk_i,
    input  logic              echo_strap_i,
    output logic              sdata_o,
    output logic              dco_o,
    output logic              busy_o,
    output logic              lost_o
);
    localparam logic SELF_FIRST = (EARLY_REV == 0);

    logic              cnv_rise, cnv_fall_unused;
    logic              sclk_rise_unused, sclk_fall;
    logic              load, cut, blank;
    logic [DATA_W-1:0] word;

    adc_ser_edge u_cnv_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (cnv_i),
        .rise_o (cnv_rise),
        .fall_o (cnv_fall_unused)
    );

    adc_ser_edge u_sclk_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (sclk_i),
        .rise_o (sclk_rise_unused),
        .fall_o (sclk_fall)
    );

    adc_ser_conv #(
        .DATA_W  (DATA_W),
        .LAT_CYC (LAT_CYC),
        .CUT_CYC (CUT_CYC)
    ) u_conv (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_rise_i (cnv_rise),
        .sample_i     (sample_i),
        .busy_o       (busy_o),
        .load_o       (load),
        .cut_o        (cut),
        .blank_o      (blank),
        .word_o       (word)
    );

    adc_ser_shift #(
        .DATA_W    (DATA_W),
        .EARLY_REV (EARLY_REV)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .cut_i       (cut),
        .fall_i      (sclk_fall),
        .echo_mode_i (echo_strap_i),
        .word_i      (word),
        .sdata_o     (sdata_o),
        .lost_o      (lost_o)
    );

    assign dco_o = echo_strap_i & ~blank & sclk_i;

    assert_blank_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (!sdata_o && !dco_o));

    assert_first_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sdata_o == $past(echo_strap_i ? word[DATA_W-1] : SELF_FIRST)));
endmodule

// File: tb/tb_adc_ser_model.sv
module tb_adc_ser_model;
    localparam int LAT = 32;
    localparam int CUT = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnv = 1'b0;
    logic [15:0] sample = '0;
    logic        sclk = 1'b0;
    logic        echo = 1'b1;
    logic        sdata0, dco0, busy0, lost0;
    logic        sdata1, dco1, busy1, lost1;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    adc_ser_model #(.DATA_W(16), .LAT_CYC(LAT), .CUT_CYC(CUT), .EARLY_REV(0)) dut (
        .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sample_i(sample), .sclk_i(sclk),
        .echo_strap_i(echo), .sdata_o(sdata0), .dco_o(dco0), .busy_o(busy0), .lost_o(lost0));

    adc_ser_model #(.DATA_W(16), .LAT_CYC(LAT), .CUT_CYC(CUT), .EARLY_REV(1)) dut_rev0 (
        .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sample_i(sample), .sclk_i(sclk),
        .echo_strap_i(echo), .sdata_o(sdata1), .dco_o(dco1), .busy_o(busy1), .lost_o(lost1));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] sweep_val(input int i);
        if (i < 16)       return 16'(1) << i;
        else if (i == 16) return 16'h0000;
        else if (i == 17) return 16'hFFFF;
        else if (i == 18) return 16'h7FFF;
        else if (i == 19) return 16'h8001;
        else              return 16'(i * 40503);
    endfunction

    // Called at a negedge; returns at the negedge after the result loads.
    task automatic strobe_wait(input logic [15:0] v, output int n);
        sample = v;
        cnv = 1'b1;
        @(negedge clk);
        cnv = 1'b0;
        n = 0;
        while (busy0 && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Each pulse: high two half-periods, low for two clocks; bit sampled while high.
    task automatic read_bits(input int n, output logic [19:0] a, output logic [19:0] b, output bit dco_ok);
        a = '0;
        b = '0;
        dco_ok = 1'b1;
        for (int p = 0; p < n; p++) begin
            sclk = 1'b1;
            @(negedge clk);
            a = {a[18:0], sdata0};
            b = {b[18:0], sdata1};
            if (dco0 !== echo || dco1 !== echo) dco_ok = 1'b0;
            sclk = 1'b0;
            @(negedge clk);
            if (dco0 !== 1'b0) dco_ok = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [19:0] a, b;
        bit          ok;
        int          n;
        logic [15:0] v;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        chk(!busy0 && !sdata0 && !lost0 && !dco0, "R9 reset outputs",
            {busy0, sdata0, lost0, dco0}, 4'b0000);

        // R10: shift pulses before any result
        read_bits(3, a, b, ok);
        chk(a == '0 && b == '0, "R10 idle pulses", a, 20'h0);

        // Echoed-clock sweep: R1, R3, R4, R6
        echo = 1'b1;
        for (int i = 0; i < 24; i++) begin
            v = sweep_val(i);
            strobe_wait(v, n);
            if (i < 4) chk(n == LAT, "R1 busy length", n, LAT);
            chk(sdata0 == v[15] && sdata1 == v[15], "R3 echo first bit", {sdata0, sdata1}, {v[15], v[15]});
            read_bits(16, a, b, ok);
            chk(a[15:0] == v, "R4 echo word", a[15:0], v);
            chk(b[15:0] == v, "R4 echo word early rev", b[15:0], v);
            chk(ok, "R6 echoed clock copy", ok, 1);
            chk(!sdata0 && !sdata1, "R4 line low after 16 pulses", {sdata0, sdata1}, 2'b00);
        end

        // R10: pulses after a completed word
        read_bits(2, a, b, ok);
        chk(a[1:0] == 2'b00 && b[1:0] == 2'b00, "R10 pulses after word", {a[1:0], b[1:0]}, 4'b0);

        // R2: second strobe mid-conversion and on the final busy cycle
        sample = 16'h1234;
        cnv = 1'b1;
        @(negedge clk);
        cnv = 1'b0;
        n = 0;
        while (busy0 && n < 1000) begin
            n++;
            if (n == 5) begin
                sample = 16'hBEEF;
                cnv = 1'b1;
            end
            if (n == 6) cnv = 1'b0;
            if (n == LAT) cnv = 1'b1;
            @(negedge clk);
        end
        chk(n == LAT, "R2 busy length unchanged", n, LAT);
        cnv = 1'b0;
        @(negedge clk);
        chk(!busy0, "R2 no restart from last-cycle strobe", busy0, 0);
        read_bits(16, a, b, ok);
        chk(a[15:0] == 16'h1234, "R2 captured word kept", a[15:0], 16'h1234);

        // Self-clocked sweep: R3, R5, R6
        echo = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 24; i++) begin
            v = sweep_val(i) ^ 16'h0F0F;
            strobe_wait(v, n);
            chk(sdata0 == 1'b1 && sdata1 == 1'b0, "R3 self first bit", {sdata0, sdata1}, 2'b10);
            read_bits(19, a, b, ok);
            chk(a[18:0] == {2'b10, v, 1'b0}, "R5 self frame 18 pulses", a[18:0], {2'b10, v, 1'b0});
            chk(b[18:0] == {3'b010, v}, "R5 self frame early rev", b[18:0], {3'b010, v});
            chk(ok, "R6 echoed clock low in self mode", ok, 1);
            chk(!sdata0 && !sdata1, "R5 line low after frame", {sdata0, sdata1}, 2'b00);
        end

        // R7, R8: window closes after k of 16 bits
        echo = 1'b1;
        @(negedge clk);
        for (int t = 0; t < 6; t++) begin
            int k;
            k = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 7 : (t == 3) ? 14 : (t == 4) ? 15 : 16;
            v = 16'hC3A5 ^ 16'(t * 291);
            strobe_wait(v, n);
            read_bits(k, a, b, ok);
            sample = ~v;
            cnv = 1'b1;
            @(negedge clk);
            cnv = 1'b0;
            sclk = 1'b1;
            repeat (CUT - 1) @(negedge clk);
            chk(!lost0 && dco0, "R7 window still open", {lost0, dco0}, 2'b01);
            @(negedge clk);
            chk(lost0 == (k < 16) && lost1 == (k < 16), "R8 loss flag at cut",
                {lost0, lost1}, {(k < 16), (k < 16)});
            chk(!sdata0 && !dco0 && !sdata1 && !dco1, "R7 line and clock dark",
                {sdata0, dco0, sdata1, dco1}, 4'b0);
            sclk = 1'b0;
            n = 0;
            while (busy0 && n < 1000) begin
                n++;
                @(negedge clk);
            end
            chk(!lost0 && !lost1, "R8 flag cleared by load", {lost0, lost1}, 2'b00);
            read_bits(16, a, b, ok);
            chk(a[15:0] == ~v, "R8 next word intact", a[15:0], ~v);
        end

        finish_run();
    end
endmodule